// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels that share one configuration byte, one run/flag byte and a byte-wide register port. Each channel keeps a 16-bit count split into a low and a high byte, both readable and writable on their own. The configuration byte chooses, for each channel, how the count is organised (13-bit with a 5-bit prescaler, full 16-bit, 8-bit with automatic reload, or split into two 8-bit counters), whether counting needs an external qualifying pin to be high, and whether the channel advances on machine cycles or on falling edges of an external count pin.

Counting is paced by a one-clock machine-cycle enable supplied from outside. External count pins and qualifying pins pass through two-flop synchronizers. The count pin is sampled once per machine cycle, and a high sample followed by a low sample counts once. A rollover from all ones to zero raises the channel's overflow flag. The interrupt controller lowers the flag with a one-cycle clear pulse, and software may write or poll the flag through the register port.

When channel 0 is split, its low byte keeps channel 0's controls and flag. Its high byte becomes a free 8-bit timer that counts machine cycles whenever channel 1's run bit is set, and it raises channel 1's flag.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0x00 and both overflow flags are low.
- R2: Register address 0 is the configuration byte, read back as written. Bits [3:0] configure channel 0 and bits [7:4] configure channel 1. Within a nibble, bits [1:0] are the mode (00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split), bit 2 selects external-edge counting when 1, and bit 3 enables pin qualification when 1.
- R3: In mode 00, each count step increments only the low byte's bits [4:0]. When they wrap from 31 to 0, the high byte increments, and a wrap of the high byte from 0xFF to 0x00 sets the flag. Low-byte bits [7:5] never change by counting.
- R4: In mode 01, the low and high bytes form one 16-bit count. A step from 0xFFFF to 0x0000 sets the channel's flag.
- R5: In mode 10, the low byte counts. A step from 0xFF loads the low byte from the high byte and sets the flag, and the high byte never changes by counting.
- R6: With channel 0 in mode 11, its low byte is an 8-bit counter under channel 0's controls that sets flag 0. Its high byte advances once per machine cycle while channel 1's run bit is 1, and it sets flag 1 when it wraps from 0xFF.
- R7: Channel 1 in mode 11 holds both of its count bytes.
- R8: Address 1 holds run bits in bits [1:0] (channel 0 in bit 0) and flags in bits [3:2]. A channel whose run bit is 0 does not count.
- R9: With pin qualification enabled, a channel counts only while its synchronized qualifying pin is high.
- R10: In external mode, the count pin passes through two flops and is sampled on each machine-cycle enable. A high sample followed by a low sample gives exactly one count, and a pulse that falls between two samples gives none.
- R11: A clear pulse lowers a channel's flag. A register write to address 1 sets the flags to the written value. An overflow in the same cycle as either of these leaves the flag set.
- R12: Addresses 2/3 are channel 0 low/high and 4/5 are channel 1 low/high. A write to a count byte takes the written value even in a cycle where that byte would count, and addresses 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle enable, one clock wide |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, same cycle |
| ext_cnt | input | 2 | External count pins, one per channel |
| ext_gate | input | 2 | Qualifying pins, one per channel |
| ack_clr | input | 2 | Flag clear pulses from the interrupt controller |
| ovf_flag | output | 2 | Overflow flags |

## Verification
A wrong prescaler width, a misplaced carry or a bad reload appears at the read port within one machine cycle of the step that went wrong. It then shows as a count byte that differs from the reference. A wrong synchronizer depth or edge rule moves a count by one machine cycle or drops it, which shows on the next read of that byte. Flag errors reach ovf_flag one clock after the overflow, clear pulse or write. Because the bench compares the addressed register and both flags against its own model on every clock, the first divergence is reported in the cycle it happens.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int BYTE_W = 8;
    parameter int PRE_W  = 5;
    parameter int CH_N   = 2;
    parameter int ADDR_W = 3;

    typedef enum logic [1:0] {
        MD_PRE13   = 2'b00,
        MD_FULL16  = 2'b01,
        MD_RELOAD8 = 2'b10,
        MD_SPLIT   = 2'b11
    } tmr_mode_e;

    // one nibble of the configuration byte
    typedef struct packed {
        logic      gate;
        logic      ext;
        tmr_mode_e mode;
    } chan_cfg_t;

    typedef chan_cfg_t [CH_N-1:0] cfg_pair_t;

    localparam logic [ADDR_W-1:0] A_CFG = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTL = 3'd1;
    localparam logic [ADDR_W-1:0] A_LO0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_HI0 = 3'd3;
    localparam logic [ADDR_W-1:0] A_LO1 = 3'd4;
    localparam logic [ADDR_W-1:0] A_HI1 = 3'd5;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] gate_in,
    output logic [N-1:0] fall,
    output logic [N-1:0] gate_ok
);
    typedef struct packed {
        logic [N-1:0] p1;
        logic [N-1:0] p2;
        logic [N-1:0] samp;
        logic [N-1:0] g1;
        logic [N-1:0] g2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.p1 = pin;
        st_d.p2 = st_q.p1;
        st_d.g1 = gate_in;
        st_d.g2 = st_q.g1;
        if (tick) st_d.samp = st_q.p2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall    = {N{tick}} & st_q.samp & ~st_q.p2;
    assign gate_ok = st_q.g2;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R10
        fall_resample_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !st_q.samp[i]);
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b0
) (
    input  tmr_mode_e         mode,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic              inc,
    input  logic              hi_inc,
    output logic [BYTE_W-1:0] lo_n,
    output logic [BYTE_W-1:0] hi_n,
    output logic              ovf,
    output logic              ovf_hi
);
    localparam int FULL_W = 2 * BYTE_W;

    logic [PRE_W:0]  pre_sum;
    logic [BYTE_W:0] lo_sum;
    logic [BYTE_W:0] hi_sum;
    logic [FULL_W:0] full_sum;

    always_comb begin
        pre_sum  = {1'b0, lo[PRE_W-1:0]} + 1'b1;
        lo_sum   = {1'b0, lo} + 1'b1;
        hi_sum   = {1'b0, hi} + 1'b1;
        full_sum = {1'b0, hi, lo} + 1'b1;
        lo_n     = lo;
        hi_n     = hi;
        ovf      = 1'b0;
        ovf_hi   = 1'b0;
        case (mode)
            MD_PRE13: begin
                if (inc) begin
                    lo_n[PRE_W-1:0] = pre_sum[PRE_W-1:0];
                    if (pre_sum[PRE_W]) begin
                        hi_n = hi_sum[BYTE_W-1:0];
                        ovf  = hi_sum[BYTE_W];
                    end
                end
            end
            MD_FULL16: begin
                if (inc) begin
                    {hi_n, lo_n} = full_sum[FULL_W-1:0];
                    ovf          = full_sum[FULL_W];
                end
            end
            MD_RELOAD8: begin
                if (inc) begin
                    if (lo_sum[BYTE_W]) begin
                        lo_n = hi;
                        ovf  = 1'b1;
                    end else begin
                        lo_n = lo_sum[BYTE_W-1:0];
                    end
                end
            end
            default: begin
                if (SPLIT_OK) begin
                    if (inc) begin
                        lo_n = lo_sum[BYTE_W-1:0];
                        ovf  = lo_sum[BYTE_W];
                    end
                    if (hi_inc) begin
                        hi_n   = hi_sum[BYTE_W-1:0];
                        ovf_hi = hi_sum[BYTE_W];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [CH_N-1:0]   ext_cnt,
    input  logic [CH_N-1:0]   ext_gate,
    input  logic [CH_N-1:0]   ack_clr,
    output logic [CH_N-1:0]   ovf_flag
);
    typedef struct packed {
        cfg_pair_t                     cfg;
        logic [CH_N-1:0]               run;
        logic [CH_N-1:0]               flag;
        logic [CH_N-1:0][BYTE_W-1:0]   lo;
        logic [CH_N-1:0][BYTE_W-1:0]   hi;
    } pair_st_t;

    pair_st_t st_d, st_q;

    logic [CH_N-1:0]             fall, gate_ok, inc, hi_inc, ovf, ovf_hi, flag_set;
    logic [CH_N-1:0][BYTE_W-1:0] lo_n, hi_n;

    tmr_sync #(.N(CH_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (mc_tick),
        .pin     (ext_cnt),
        .gate_in (ext_gate),
        .fall    (fall),
        .gate_ok (gate_ok)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        assign inc[c] = mc_tick & st_q.run[c]
                      & (~st_q.cfg[c].gate | gate_ok[c])
                      & (st_q.cfg[c].ext ? fall[c] : 1'b1);

        tmr_core #(.SPLIT_OK(c == 0)) u_core (
            .mode   (st_q.cfg[c].mode),
            .lo     (st_q.lo[c]),
            .hi     (st_q.hi[c]),
            .inc    (inc[c]),
            .hi_inc (hi_inc[c]),
            .lo_n   (lo_n[c]),
            .hi_n   (hi_n[c]),
            .ovf    (ovf[c]),
            .ovf_hi (ovf_hi[c])
        );
    end

    // channel 0 split: its high byte borrows channel 1's run bit and flag
    assign hi_inc[0]   = mc_tick & st_q.run[1] & (st_q.cfg[0].mode == MD_SPLIT);
    assign hi_inc[1]   = 1'b0;
    assign flag_set[0] = ovf[0];
    assign flag_set[1] = ovf[1] | ovf_hi[0] | ovf_hi[1];

    always_comb begin
        st_d      = st_q;
        st_d.lo   = lo_n;
        st_d.hi   = hi_n;
        st_d.flag = st_q.flag & ~ack_clr;
        if (reg_wr) begin
            case (reg_addr)
                A_CFG: st_d.cfg = cfg_pair_t'(reg_wdata);
                A_CTL: begin
                    st_d.run  = reg_wdata[1:0];
                    st_d.flag = reg_wdata[3:2];
                end
                A_LO0: st_d.lo[0] = reg_wdata;
                A_HI0: st_d.hi[0] = reg_wdata;
                A_LO1: st_d.lo[1] = reg_wdata;
                A_HI1: st_d.hi[1] = reg_wdata;
                default: ;
            endcase
        end
        st_d.flag = st_d.flag | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            A_CFG:   reg_rdata = st_q.cfg;
            A_CTL:   reg_rdata = {4'b0000, st_q.flag, st_q.run};
            A_LO0:   reg_rdata = st_q.lo[0];
            A_HI0:   reg_rdata = st_q.hi[0];
            A_LO1:   reg_rdata = st_q.lo[1];
            A_HI1:   reg_rdata = st_q.hi[1];
            default: reg_rdata = '0;
        endcase
    end

    assign ovf_flag = st_q.flag;

    // R8
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run[0] && !reg_wr) |=> st_q.lo[0] == $past(st_q.lo[0]));

    // R4
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg[0].mode == MD_FULL16 && inc[0] && (&{st_q.hi[0], st_q.lo[0]}) && !reg_wr)
        |=> (st_q.flag[0] && st_q.lo[0] == '0 && st_q.hi[0] == '0));

    // R5
    reload_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg[1].mode == MD_RELOAD8 && !reg_wr) |=> st_q.hi[1] == $past(st_q.hi[1]));

    // R7
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg[1].mode == MD_SPLIT && !reg_wr)
        |=> (st_q.lo[1] == $past(st_q.lo[1]) && st_q.hi[1] == $past(st_q.hi[1])));

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr[0] && !ovf[0] && !reg_wr) |=> !ovf_flag[0]);

    // R6
    split_hi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_inc[0] && (&st_q.hi[0]) && !reg_wr) |=> ovf_flag[1]);
endmodule

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
    logic       clk = 1'b0, rst_n = 1'b0, mc_tick = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] ext_cnt = '0, ext_gate = '0, ack_clr = '0;
    logic [7:0] reg_rdata;
    logic [1:0] ovf_flag;

    tmr_pair u0 (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_cnt(ext_cnt), .ext_gate(ext_gate), .ack_clr(ack_clr), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    string phase = "R1";
    bit    tick_auto = 1'b0;
    int    tdiv = 0;

    // reference model state
    int m_cfg, m_run[2], m_flag[2], m_lo[2], m_hi[2];
    int p1[2], p2[2], samp[2], g1[2], g2[2];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_reg(int a);
        case (a)
            0: return m_cfg;
            1: return m_run[0] | (m_run[1] << 1) | (m_flag[0] << 2) | (m_flag[1] << 3);
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 0;
        endcase
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        int inc[2], nlo[2], nhi[2], ov[2], ovh, md, ex, gt, n, wa;
        if (!rst_n) begin
            m_cfg = 0;
            for (int c = 0; c < 2; c++) begin
                m_run[c] = 0; m_flag[c] = 0; m_lo[c] = 0; m_hi[c] = 0;
                p1[c] = 0; p2[c] = 0; samp[c] = 0; g1[c] = 0; g2[c] = 0;
            end
        end else begin
            ovh = 0;
            for (int c = 0; c < 2; c++) begin
                md = (m_cfg >> (4*c)) & 3;
                ex = (m_cfg >> (4*c+2)) & 1;
                gt = (m_cfg >> (4*c+3)) & 1;
                inc[c] = (mc_tick && m_run[c] != 0 && (gt == 0 || g2[c] != 0)
                          && (ex == 0 || (samp[c] != 0 && p2[c] == 0))) ? 1 : 0;
                nlo[c] = m_lo[c]; nhi[c] = m_hi[c]; ov[c] = 0;
                if (inc[c] != 0) begin
                    if (md == 0) begin
                        n = m_hi[c]*32 + (m_lo[c] % 32) + 1;
                        if (n == 8192) begin n = 0; ov[c] = 1; end
                        nlo[c] = (m_lo[c] & 224) | (n % 32);
                        nhi[c] = n / 32;
                    end else if (md == 1) begin
                        n = m_hi[c]*256 + m_lo[c] + 1;
                        if (n == 65536) begin n = 0; ov[c] = 1; end
                        nlo[c] = n % 256; nhi[c] = n / 256;
                    end else if (md == 2) begin
                        if (m_lo[c] == 255) begin nlo[c] = m_hi[c]; ov[c] = 1; end
                        else nlo[c] = m_lo[c] + 1;
                    end else if (c == 0) begin
                        nlo[c] = (m_lo[c] + 1) % 256;
                        ov[c] = (m_lo[c] == 255) ? 1 : 0;
                    end
                end
            end
            if ((m_cfg & 3) == 3 && mc_tick && m_run[1] != 0) begin
                nhi[0] = (m_hi[0] + 1) % 256;
                ovh = (m_hi[0] == 255) ? 1 : 0;
            end
            for (int c = 0; c < 2; c++) if (ack_clr[c]) m_flag[c] = 0;
            if (reg_wr) begin
                wa = int'(reg_addr);
                case (wa)
                    0: m_cfg = int'(reg_wdata);
                    1: begin
                        m_run[0] = reg_wdata[0]; m_run[1] = reg_wdata[1];
                        m_flag[0] = reg_wdata[2]; m_flag[1] = reg_wdata[3];
                    end
                    2: nlo[0] = int'(reg_wdata);
                    3: nhi[0] = int'(reg_wdata);
                    4: nlo[1] = int'(reg_wdata);
                    5: nhi[1] = int'(reg_wdata);
                    default: ;
                endcase
            end
            if (ov[0] != 0) m_flag[0] = 1;
            if (ov[1] != 0 || ovh != 0) m_flag[1] = 1;
            for (int c = 0; c < 2; c++) begin
                m_lo[c] = nlo[c]; m_hi[c] = nhi[c];
                if (mc_tick) samp[c] = p2[c];
                p2[c] = p1[c]; p1[c] = ext_cnt[c];
                g2[c] = g1[c]; g1[c] = ext_gate[c];
            end
        end
    end

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(phase, int'(reg_rdata), exp_reg(int'(reg_addr)));
            chk(phase, int'(ovf_flag), m_flag[0] | (m_flag[1] << 1));
        end
    end

    // free-running machine-cycle enable
    always @(posedge clk) begin
        #1;
        if (tick_auto) begin
            mc_tick = (tdiv == 11);
            tdiv = (tdiv + 1) % 12;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        step(); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        step(); reg_wr = 1'b0;
    endtask

    task automatic tick_n(int n);
        tick_auto = 1'b0;
        repeat (n) begin step(); mc_tick = 1'b1; step(); mc_tick = 1'b0; end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            step();
            reg_addr = (reg_addr >= 3'd5) ? 3'd0 : reg_addr + 3'd1;
        end
    endtask

    task automatic rd(input logic [2:0] a, string req, int exp);
        step(); reg_addr = a;
        @(negedge clk);
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic flags(string req, int exp);
        @(negedge clk);
        chk(req, int'(ovf_flag), exp);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), "R1", 0);
        flags("R1", 0);

        phase = "R2";
        wr(3'd0, 8'hA5); rd(3'd0, "R2", 8'hA5);
        rd(3'd6, "R12", 0);
        wr(3'd0, 8'h00);

        phase = "R3";
        wr(3'd2, 8'hFF); wr(3'd3, 8'h07); wr(3'd1, 8'h01);
        tick_n(1);
        rd(3'd2, "R3", 8'hE0); rd(3'd3, "R3", 8'h08); flags("R3", 0);
        wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
        tick_n(1);
        rd(3'd2, "R3", 8'h00); rd(3'd3, "R3", 8'h00); flags("R3", 1);

        phase = "R4";
        wr(3'd1, 8'h00); wr(3'd0, 8'h01);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
        tick_n(1); flags("R4", 0);
        tick_n(1); flags("R4", 1);
        rd(3'd3, "R4", 8'h00);

        phase = "R11";
        step(); ack_clr = 2'b01; step(); ack_clr = 2'b00;
        flags("R11", 0);
        wr(3'd3, 8'hFF); wr(3'd2, 8'hFF);
        step(); mc_tick = 1'b1; ack_clr = 2'b01;
        step(); mc_tick = 1'b0; ack_clr = 2'b00;
        flags("R11", 1);
        wr(3'd1, 8'h08); flags("R11", 2);

        phase = "R5";
        wr(3'd1, 8'h00); wr(3'd0, 8'h02);
        wr(3'd3, 8'h80); wr(3'd2, 8'hFF); wr(3'd1, 8'h01);
        tick_n(1);
        rd(3'd2, "R5", 8'h80); rd(3'd3, "R5", 8'h80); flags("R5", 1);
        tick_n(1); rd(3'd2, "R5", 8'h81);

        phase = "R6";
        wr(3'd1, 8'h00); wr(3'd0, 8'h03);
        wr(3'd3, 8'hFE); wr(3'd2, 8'h10); wr(3'd1, 8'h02);
        tick_n(2);
        rd(3'd3, "R6", 8'h00); rd(3'd2, "R6", 8'h10); flags("R6", 2);

        phase = "R7";
        wr(3'd1, 8'h00); wr(3'd0, 8'h30);
        wr(3'd4, 8'h33); wr(3'd5, 8'h44); wr(3'd1, 8'h02);
        tick_n(3);
        rd(3'd4, "R7", 8'h33); rd(3'd5, "R7", 8'h44); flags("R7", 0);

        phase = "R8";
        wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'h12);
        tick_n(3); rd(3'd2, "R8", 8'h12);

        phase = "R9";
        wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
        tick_n(3); rd(3'd2, "R9", 0);
        ext_gate = 2'b01; repeat (3) step();
        tick_n(2); rd(3'd2, "R9", 2);
        ext_gate = 2'b00;

        phase = "R10";
        wr(3'd1, 8'h00); wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd1, 8'h01);
        ext_cnt = 2'b01; repeat (3) step(); tick_n(1);
        ext_cnt = 2'b00; repeat (3) step(); tick_n(1);
        tick_n(1); rd(3'd2, "R10", 1);
        ext_cnt = 2'b01; repeat (3) step(); ext_cnt = 2'b00; repeat (3) step();
        tick_n(1); rd(3'd2, "R10", 1);

        phase = "R12";
        wr(3'd0, 8'h01);
        step(); mc_tick = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h55; reg_wr = 1'b1;
        step(); mc_tick = 1'b0; reg_wr = 1'b0;
        rd(3'd2, "R12", 8'h55);

        // mixed soak against the model under free-running machine cycles
        phase = "R9 R10 R11 R12";
        tick_auto = 1'b1;
        for (int k = 0; k < 400; k++) begin
            ext_cnt  = 2'($urandom);
            ext_gate = 2'($urandom);
            ack_clr  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            if ($urandom % 6 == 0) wr(3'($urandom % 6), 8'($urandom));
            else idle(1 + $urandom % 7);
            ack_clr = 2'b00;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule